// File: doc/BRIEF.md
# Receive Destination Host Filter

This block sits in a receive path and decides whether an incoming packet is kept. The decision is based only on the packet's 8-bit destination host byte. A 16-bit mode/host word sets the behaviour. Any value except all ones selects exact-match mode, where a packet is kept if its destination equals the programmed host or is the broadcast host. The all-ones value selects vector mode, where a 256-bit accept map, one bit per host number, makes the decision.

Software loads the accept map 16 bits at a time before it writes all ones to the mode/host word. Writing a non-negative host value later returns the filter to exact-match mode, and the map keeps its contents. Each lookup is started by a one-cycle strobe with the destination byte. The keep/drop decision comes out, registered, on the next cycle together with a valid flag.

Top module: `rx_host_filter`

## Requirements
- R1: After reset, dec_valid and dec_accept are 0, the mode/host word is 0 (exact-match mode, host 0), and every accept-map bit is 0.
- R2: In exact-match mode, a lookup is accepted when the 16-bit mode/host word equals the destination byte zero-extended to 16 bits. Otherwise it is rejected, unless R3 applies.
- R3: Destination host 0 is the broadcast host, and in exact-match mode it is always accepted.
- R4: When the mode/host word is 16'hFFFF, a lookup is accepted exactly when accept-map bit [dst] is 1. Bit j of map word k (vec_idx = k) holds host 16*k + j.
- R5: In vector mode, broadcast (host 0, map word 0 bit 0) follows its map bit, so clearing that bit rejects broadcast packets.
- R6: Writing a non-all-ones value to the mode/host word returns the filter to exact-match mode. The accept map keeps its contents across mode changes.
- R7: dec_valid is 1 in the cycle after each cycle where dst_valid is 1, and 0 otherwise. dec_accept is 0 whenever dec_valid is 0.
- R8: A map write or a mode/host write in the same cycle as a lookup does not affect that lookup, which uses the contents from before the write.
- R9: A mode/host word with bit 15 set but not all ones is exact-match mode that matches no non-zero destination. In exact-match mode the map contents have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the mode/host word |
| cfg_data | input | 16 | New mode/host word (16'hFFFF selects vector mode) |
| vec_we | input | 1 | Write strobe for one accept-map word |
| vec_idx | input | 4 | Accept-map word index |
| vec_data | input | 16 | Accept-map word contents, bit j for host 16*idx+j |
| dst_valid | input | 1 | Lookup strobe |
| dst_host | input | 8 | Destination host byte of the packet |
| dec_valid | output | 1 | Decision valid, one cycle after dst_valid |
| dec_accept | output | 1 | 1 = keep packet, 0 = drop |

## Verification
A wrong bit in the accept map shows at the ports only when vector mode is active and a lookup hits that exact host. The bench therefore sweeps many hosts in every map word after loading distinct patterns, and a corruption is visible on the first such lookup, one cycle after its strobe. A wrong mode/host word shows on the next lookup as a kept or dropped packet that the reference model disagrees with. A write-versus-lookup ordering fault shows only when both happen in the same cycle, so the bench makes such collisions directly and also causes them in a random phase.

// File: rtl/rhf_pkg.sv
package rhf_pkg;
  localparam int unsigned CFG_W = 16;

  typedef logic [CFG_W-1:0] host_word_t;

  typedef enum logic {
    MODE_EXACT  = 1'b0,
    MODE_VECTOR = 1'b1
  } filter_mode_e;

  // All ones selects the accept map; every other value is an exact host.
  function automatic filter_mode_e select_mode(input host_word_t w);
    return (&w) ? MODE_VECTOR : MODE_EXACT;
  endfunction

  // Exact-match hit: full-width compare against the zero-extended destination.
  function automatic logic exact_hit(input host_word_t w, input host_word_t dst_ext);
    return (w == dst_ext);
  endfunction

  // Broadcast is the all-zero destination.
  function automatic logic is_broadcast(input host_word_t dst_ext);
    return (dst_ext == '0);
  endfunction
endpackage

// File: rtl/rhf_mode_reg.sv
module rhf_mode_reg
  import rhf_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  host_word_t   cfg_data,
  output host_word_t   host_word,
  output filter_mode_e mode
);
  host_word_t word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (cfg_we) word_q <= cfg_data;
  end

  assign host_word = word_q;
  assign mode      = select_mode(word_q);

  // R6: a written word is what the filter holds on the next cycle
  a_r6_cfg_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (host_word == $past(cfg_data)));

  // R6: without a write the mode/host word holds
  a_r6_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(host_word));
endmodule

// File: rtl/rhf_vec_store.sv
module rhf_vec_store #(
  parameter  int HOST_W    = 8,
  parameter  int WORD_W    = 16,
  localparam int NUM_HOSTS = 1 << HOST_W,
  localparam int NUM_WORDS = NUM_HOSTS / WORD_W,
  localparam int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vec_we,
  input  logic [IDX_W-1:0]  vec_idx,
  input  logic [WORD_W-1:0] vec_data,
  input  logic [HOST_W-1:0] rd_host,
  output logic              rd_bit
);
  logic [NUM_HOSTS-1:0] map_flat;
  logic [NUM_WORDS-1:0] word_sel;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;

    assign word_sel[g] = vec_we && (vec_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           word_q <= '0;
      else if (word_sel[g]) word_q <= vec_data;
    end

    assign map_flat[g*WORD_W +: WORD_W] = word_q;
  end

  // Read sees the registered contents, so a same-cycle write is not visible.
  assign rd_bit = map_flat[rd_host];

  // R4: at most one word is selected per write
  a_r4_one_word: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(word_sel));

  // R4: a written word appears at its index on the next cycle
  a_r4_word_lands: assert property (@(posedge clk) disable iff (!rst_n)
    vec_we |=> (map_flat[int'($past(vec_idx))*WORD_W +: WORD_W] == $past(vec_data)));

  // R6: without a write the whole map holds
  a_r6_map_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_we |=> $stable(map_flat));
endmodule

// File: rtl/rhf_decide.sv
module rhf_decide
  import rhf_pkg::*;
#(
  parameter int HOST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dst_valid,
  input  logic [HOST_W-1:0] dst_host,
  input  host_word_t        host_word,
  input  filter_mode_e      mode,
  input  logic              map_bit,
  output logic              dec_valid,
  output logic              dec_accept
);
  host_word_t dst_ext;
  logic       bcast_hit;
  logic       exact_match;
  logic       accept_now;

  assign dst_ext     = host_word_t'(dst_host);
  assign bcast_hit   = is_broadcast(dst_ext);
  assign exact_match = exact_hit(host_word, dst_ext);

  always_comb begin
    unique case (mode)
      MODE_VECTOR: accept_now = map_bit;
      default:     accept_now = exact_match || bcast_hit;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= dst_valid;
      dec_accept <= dst_valid && accept_now;
    end
  end

  // R7: every strobe yields a decision one cycle later
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |=> dec_valid);

  // R7: no strobe, no decision
  a_r7_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_valid |=> !dec_valid);

  // R7: accept never stands without valid
  a_r7_accept_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_accept);

  // R3: broadcast always kept in exact-match mode
  a_r3_bcast_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && mode == MODE_EXACT && bcast_hit) |=> dec_accept);

  // R4: in vector mode the decision is the map bit seen at the strobe
  a_r4_map_decides: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && mode == MODE_VECTOR) |=> (dec_accept == $past(map_bit)));

  // R9: a non-broadcast destination that misses the host word is dropped in exact mode
  a_r9_exact_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && mode == MODE_EXACT && !bcast_hit && !exact_match) |=> !dec_accept);
endmodule

// File: rtl/rx_host_filter.sv
module rx_host_filter
  import rhf_pkg::*;
#(
  parameter  int HOST_W = 8,
  parameter  int WORD_W = 16,
  localparam int IDX_W  = $clog2((1 << HOST_W) / WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              vec_we,
  input  logic [IDX_W-1:0]  vec_idx,
  input  logic [WORD_W-1:0] vec_data,
  input  logic              dst_valid,
  input  logic [HOST_W-1:0] dst_host,
  output logic              dec_valid,
  output logic              dec_accept
);
  host_word_t   host_word;
  filter_mode_e mode;
  logic         map_bit;

  rhf_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_data  (cfg_data),
    .host_word (host_word),
    .mode      (mode)
  );

  rhf_vec_store #(
    .HOST_W (HOST_W),
    .WORD_W (WORD_W)
  ) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .vec_we   (vec_we),
    .vec_idx  (vec_idx),
    .vec_data (vec_data),
    .rd_host  (dst_host),
    .rd_bit   (map_bit)
  );

  rhf_decide #(
    .HOST_W (HOST_W)
  ) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .dst_valid  (dst_valid),
    .dst_host   (dst_host),
    .host_word  (host_word),
    .mode       (mode),
    .map_bit    (map_bit),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept)
  );
endmodule

// File: tb/sim_rx_host_filter.sv
`timescale 1ns/1ps
module sim_rx_host_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_data = '0;
  logic        vec_we = 1'b0;
  logic [3:0]  vec_idx = '0;
  logic [15:0] vec_data = '0;
  logic        dst_valid = 1'b0;
  logic [7:0]  dst_host = '0;
  logic        dec_valid;
  logic        dec_accept;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  string phase   = "R1";

  always #4 clk = ~clk;

  rx_host_filter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .vec_we(vec_we), .vec_idx(vec_idx), .vec_data(vec_data),
    .dst_valid(dst_valid), .dst_host(dst_host),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  // Behavioural reference: a host number, a bit array, and the rules as written.
  int unsigned m_host = 0;
  bit          m_map [256];
  bit          exp_v = 1'b0;
  bit          exp_a = 1'b0;

  function automatic bit model_keep(int unsigned h, int unsigned d);
    if (h == 32'h0000_FFFF) return m_map[d];
    if (d == 0) return 1'b1;
    return (h == d);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_v  = 1'b0;
      exp_a  = 1'b0;
      m_host = 0;
      for (int i = 0; i < 256; i++) m_map[i] = 1'b0;
    end else begin
      exp_v = dst_valid;
      exp_a = dst_valid && model_keep(m_host, int'(dst_host));
      if (cfg_we) m_host = int'(cfg_data);
      if (vec_we)
        for (int j = 0; j < 16; j++) m_map[int'(vec_idx)*16 + j] = vec_data[j];
    end
  end

  // Compare on every clock, 2 ns after the edge.
  always @(posedge clk) begin
    #2;
    if (!done) begin
      n_tests++;
      if (dec_valid !== exp_v || dec_accept !== exp_a) begin
        n_fail++;
        $display("FAIL %s: valid=%0b accept=%0b expected valid=%0b accept=%0b (t=%0t)",
                 phase, dec_valid, dec_accept, exp_v, exp_a, $time);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    cfg_we = 0; vec_we = 0; dst_valid = 0;
  endtask

  task automatic set_host(input logic [15:0] w);
    @(negedge clk);
    cfg_we = 1; cfg_data = w; vec_we = 0; dst_valid = 0;
    idle();
  endtask

  task automatic load_word(input int k, input logic [15:0] d);
    @(negedge clk);
    vec_we = 1; vec_idx = 4'(k); vec_data = d; cfg_we = 0; dst_valid = 0;
    idle();
  endtask

  task automatic probe(input int h);
    @(negedge clk);
    dst_valid = 1; dst_host = 8'(h); cfg_we = 0; vec_we = 0;
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    phase = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(); idle();
    probe(0);   // host word 0: broadcast kept
    probe(5);
    set_host(16'hFFFF);
    probe(8'h37); probe(0); probe(255);   // map cleared after reset

    // R2 and R3: exact-match mode
    phase = "R2";
    set_host(16'h0042);
    probe(8'h42); probe(8'h43); probe(8'hFF); probe(8'h02);
    phase = "R3";
    probe(0);
    set_host(16'h00FF);
    probe(8'hFF); probe(0); probe(8'hFE);

    // R4: load distinct patterns, then vector mode
    phase = "R4";
    for (int k = 0; k < 16; k++) load_word(k, 16'hA5C3 ^ 16'(k * 16'h1111) ^ 16'h0001);
    set_host(16'hFFFF);
    for (int h = 0; h < 256; h += 3) probe(h);
    probe(255); probe(16); probe(17);

    // R5: broadcast follows map bit 0 of word 0
    phase = "R5";
    load_word(0, 16'h0000);
    probe(0);
    load_word(0, 16'h0001);
    probe(0);

    // R8: writes in the same cycle as a lookup
    phase = "R8";
    @(negedge clk);
    dst_valid = 1; dst_host = 8'h21; vec_we = 1; vec_idx = 4'd2; vec_data = 16'hFFFF;
    idle();
    probe(8'h21);
    @(negedge clk);
    dst_valid = 1; dst_host = 8'h21; vec_we = 1; vec_idx = 4'd2; vec_data = 16'h0000;
    idle();
    probe(8'h21);
    @(negedge clk);
    dst_valid = 1; dst_host = 8'h30; cfg_we = 1; cfg_data = 16'h0030;
    idle();
    probe(8'h30);

    // R6: leave vector mode, map kept
    phase = "R6";
    load_word(5, 16'h00F0);
    set_host(16'h0010);
    probe(8'h10); probe(8'h54); probe(8'h55);
    set_host(16'hFFFF);
    probe(8'h54); probe(8'h50); probe(8'h10);

    // R9: other negative words, and map ignored in exact mode
    phase = "R9";
    set_host(16'h8001);
    probe(1); probe(0); probe(8'h80);
    set_host(16'h0100);
    probe(0); probe(1); probe(8'h00);
    load_word(0, 16'hFFFF);
    probe(3); probe(0);
    set_host(16'hFFFE);
    probe(8'hFE); probe(0);

    // R7: back-to-back strobes and gaps
    phase = "R7";
    set_host(16'h0007);
    @(negedge clk); dst_valid = 1; dst_host = 7;
    @(negedge clk); dst_valid = 1; dst_host = 6;
    @(negedge clk); dst_valid = 1; dst_host = 0;
    idle(); idle(); idle();

    // Random phase: all inputs mixed, R8 collisions included
    phase = "R4/R8 random";
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      dst_valid = ($urandom_range(0, 3) != 0);
      dst_host  = 8'($urandom_range(0, 255));
      vec_we    = ($urandom_range(0, 5) == 0);
      vec_idx   = 4'($urandom_range(0, 15));
      vec_data  = 16'($urandom);
      cfg_we    = ($urandom_range(0, 20) == 0);
      cfg_data  = ($urandom_range(0, 1) == 0) ? 16'hFFFF : 16'(dst_host ^ 8'($urandom_range(0, 1)));
    end
    idle(); idle(); idle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule